// File: doc/BRIEF.md
# Test Coprocessor with Timed Interrupts

This block is a verification aid that sits on a core's coprocessor request/response handshake and answers two coprocessor numbers, 4 and 5. It holds sixteen 32-bit registers that the core reads and writes with register-transfer requests. Number 4 also accepts memory load/store transfers into and out of those registers. Requests to any other number are refused.

Its data-processing requests compute nothing. They take a count from a register and use it to stall the core for that many cycles, to pull the fast or the normal interrupt line low after that many cycles, or to let either line go high again. A final opcode copies a free-running 32-bit cycle counter into a register. Test programs use these to create interrupts and stalls at known times.

Every request is answered combinationally in the cycle it is presented, and any register or line update takes effect at the following clock edge. A multi-cycle request (a busy wait or a long transfer) stays presented. Its first cycle is marked with `req_first`, and each later cycle is presented again with `req_first` low.

Top module: `timed_test_cop`

## Requirements
- R1: After reset both interrupt lines `fiq_n` and `irq_n` are high and every register reads 0.
- R2: A request of kind 0 (write register) or kind 1 (read register) on number 4 or 5 selects the register with instruction bits 19:16. The write stores `req_wdata` at the next edge. The read returns the register on `resp_rdata`. Both answer done (code 0).
- R3: A request on any number other than 4 or 5 answers "cannot handle" (code 3) and changes no register or line.
- R4: Load (kind 2) and store (kind 3) are accepted only on number 4 and select the register with instruction bits 15:12. A load writes `req_wdata` and a store returns the register on `resp_rdata`. On number 5 both answer code 3 and write nothing.
- R5: With instruction bit 22 clear, a transfer is one beat answering done. With bit 22 set, the beats answer increment (code 2) four times and done on the fifth, every beat moving the same register. A beat with `req_first` high restarts the beat count.
- R6: A data-processing request (kind 4) takes its opcode from bits 23:20 and its count from the register selected by bits 3:0. Opcode 0 (busy wait, on 4 or 5) answers done on its first cycle when the count is 0. For a count d>0 it answers busy (code 1) on exactly d cycles, the first included, then done.
- R7: On number 5, opcode 1 (fast line) and opcode 2 (normal line) answer done at once. With count 0 the line is low from the next cycle. With count d the line goes low d cycles later than it would for count 0. A new schedule on a line replaces any countdown still pending on that line.
- R8: On number 5, opcode 3 drives `fiq_n` high and opcode 4 drives `irq_n` high from the next cycle. If a countdown expires in the same cycle, the release wins.
- R9: On number 5, opcode 5 writes the cycle counter into the register selected by bits 3:0. The counter advances by one every clock, so two snapshots taken g cycles apart differ by g.
- R10: Number 4 answers code 3 to opcodes 1 to 5, and either number answers code 3 to opcodes 6 to 15. A refused request changes no register or line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request presented this cycle |
| req_first | input | 1 | First cycle or first beat of the request |
| req_kind | input | 3 | 0 write reg, 1 read reg, 2 load, 3 store, 4 data processing |
| req_cpnum | input | 4 | Coprocessor number addressed |
| req_instr | input | 32 | Instruction word |
| req_wdata | input | 32 | Data for register writes and loads |
| resp_code | output | 2 | 0 done, 1 busy, 2 increment, 3 cannot handle |
| resp_rdata | output | 32 | Register data for reads and stores, else 0 |
| fiq_n | output | 1 | Fast interrupt request, active low |
| irq_n | output | 1 | Normal interrupt request, active low |

## Verification
The assertions assume that the core presents one request per cycle. They also assume that a busy wait which is not on its first cycle follows a first cycle that started it, and that `req_valid` stays low while reset is held. The readback property further assumes that a register read directly after a write to the same register sees that write. The directed tasks respect all of this. Each scenario presents every beat at a falling edge, marks the first cycle of each busy wait and long transfer, and returns `req_valid` low between requests. Interrupt schedules use small counts, so every expiry falls inside the observed window.

// File: rtl/tcop_pkg.sv
package tcop_pkg;
  typedef enum logic [1:0] {
    RSP_DONE = 2'd0,
    RSP_BUSY = 2'd1,
    RSP_INC  = 2'd2,
    RSP_CANT = 2'd3
  } rsp_e;

  typedef enum logic [2:0] {
    K_REG_WR = 3'd0,
    K_REG_RD = 3'd1,
    K_MEM_LD = 3'd2,
    K_MEM_ST = 3'd3,
    K_DPROC  = 3'd4
  } kind_e;

  localparam int unsigned LINE_FAST = 0;
  localparam int unsigned LINE_NORM = 1;
  localparam int unsigned NUM_LINES = 2;
endpackage

// File: rtl/tcop_regfile.sv
module tcop_regfile #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 16,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    logic          en;
    logic [DW-1:0] nxt;
    always_comb begin
      en  = we && (waddr == AW'(gi));
      nxt = en ? wdata : regs_q[gi];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[gi] <= '0;
      else if (en) regs_q[gi] <= nxt;
    end
  end

  assign ra_data = regs_q[ra_addr];
  assign rb_data = regs_q[rb_addr];
endmodule

// File: rtl/tcop_timer.sv
module tcop_timer #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] count,
  output logic          finish_hit
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] fin_q, fin_d;
  logic [DW-1:0] diff;

  always_comb begin
    cnt_d = cnt_q + DW'(1);
    fin_d = start ? (cnt_q + opnd) : fin_q;
    diff  = cnt_q - fin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fin_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (start) fin_q <= fin_d;
    end
  end

  assign count      = cnt_q;
  assign finish_hit = ~diff[DW-1];
endmodule

// File: rtl/tcop_irq_line.sv
module tcop_irq_line #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sched,
  input  logic          rel,
  input  logic [DW-1:0] delay,
  output logic          line_n
);
  logic          pend_q, pend_d;
  logic [DW-1:0] rem_q, rem_d;
  logic          low_q, low_d;

  always_comb begin
    pend_d = pend_q;
    rem_d  = rem_q;
    low_d  = low_q;
    if (pend_q) begin
      rem_d = rem_q - DW'(1);
      if (rem_q == DW'(1)) begin
        pend_d = 1'b0;
        low_d  = 1'b1;
      end
    end
    if (sched) begin
      if (delay == '0) begin
        pend_d = 1'b0;
        low_d  = 1'b1;
      end else begin
        pend_d = 1'b1;
        rem_d  = delay;
        low_d  = low_q;
      end
    end
    if (rel) low_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rem_q  <= '0;
      low_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      low_q  <= low_d;
      if (pend_q || sched) rem_q <= rem_d;
    end
  end

  assign line_n = ~low_q;
endmodule

// File: rtl/tcop_decode.sv
module tcop_decode
  import tcop_pkg::*;
#(
  parameter int unsigned CP_A      = 4,
  parameter int unsigned CP_B      = 5,
  parameter int unsigned AW        = 4,
  parameter int unsigned LONG_LAST = 4,
  localparam int unsigned WCW      = $clog2(LONG_LAST + 1)
) (
  input  logic           req_valid,
  input  logic           req_first,
  input  logic [2:0]     req_kind,
  input  logic [3:0]     req_cpnum,
  input  logic [31:0]    req_instr,
  input  logic           opnd_zero,
  input  logic           finish_hit,
  input  logic [WCW-1:0] wcnt,
  output logic [1:0]     rsp,
  output logic           rd_en,
  output logic [AW-1:0]  rd_addr,
  output logic [AW-1:0]  opnd_addr,
  output logic           rf_we,
  output logic [AW-1:0]  rf_waddr,
  output logic           rf_src_cnt,
  output logic           busy_start,
  output logic [1:0]     sched,
  output logic [1:0]     rel,
  output logic           wc_we,
  output logic [WCW-1:0] wc_next
);
  logic           is_a, is_b;
  logic [3:0]     opcode;
  logic [AW-1:0]  f_rn, f_rd, f_rm;
  logic           long_x;
  logic [WCW-1:0] eff;
  logic           unused_bits;

  assign is_a        = (req_cpnum == 4'(CP_A));
  assign is_b        = (req_cpnum == 4'(CP_B));
  assign opcode      = req_instr[23:20];
  assign f_rn        = req_instr[16 +: AW];
  assign f_rd        = req_instr[12 +: AW];
  assign f_rm        = req_instr[0 +: AW];
  assign long_x      = req_instr[22];
  assign opnd_addr   = f_rm;
  assign unused_bits = ^{req_instr[31:24], req_instr[11:4]};

  always_comb begin
    rsp        = RSP_DONE;
    rd_en      = 1'b0;
    rd_addr    = f_rn;
    rf_we      = 1'b0;
    rf_waddr   = f_rn;
    rf_src_cnt = 1'b0;
    busy_start = 1'b0;
    sched      = 2'b00;
    rel        = 2'b00;
    wc_we      = 1'b0;
    eff        = req_first ? '0 : wcnt;
    wc_next    = eff + WCW'(1);
    if (req_valid) begin
      if (!(is_a || is_b)) begin
        rsp = RSP_CANT;
      end else begin
        case (kind_e'(req_kind))
          K_REG_WR: rf_we = 1'b1;
          K_REG_RD: rd_en = 1'b1;
          K_MEM_LD, K_MEM_ST: begin
            if (!is_a) begin
              rsp = RSP_CANT;
            end else begin
              rd_addr  = f_rd;
              rf_waddr = f_rd;
              if (kind_e'(req_kind) == K_MEM_LD) rf_we = 1'b1;
              else                               rd_en = 1'b1;
              if (long_x) begin
                wc_we = 1'b1;
                rsp   = (eff == WCW'(LONG_LAST)) ? RSP_DONE : RSP_INC;
              end
            end
          end
          K_DPROC: begin
            case (opcode)
              4'd0: begin
                if (req_first) begin
                  busy_start = 1'b1;
                  rsp        = opnd_zero ? RSP_DONE : RSP_BUSY;
                end else begin
                  rsp = finish_hit ? RSP_DONE : RSP_BUSY;
                end
              end
              4'd1, 4'd2: begin
                if (is_b) sched[opcode == 4'd2] = 1'b1;
                else      rsp = RSP_CANT;
              end
              4'd3, 4'd4: begin
                if (is_b) rel[opcode == 4'd4] = 1'b1;
                else      rsp = RSP_CANT;
              end
              4'd5: begin
                if (is_b) begin
                  rf_we      = 1'b1;
                  rf_waddr   = f_rm;
                  rf_src_cnt = 1'b1;
                end else begin
                  rsp = RSP_CANT;
                end
              end
              default: rsp = RSP_CANT;
            endcase
          end
          default: rsp = RSP_CANT;
        endcase
      end
    end
  end
endmodule

// File: rtl/timed_test_cop.sv
module timed_test_cop
  import tcop_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned NREG      = 16,
  parameter int unsigned CP_A      = 4,
  parameter int unsigned CP_B      = 5,
  parameter int unsigned LONG_LAST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_first,
  input  logic [2:0]    req_kind,
  input  logic [3:0]    req_cpnum,
  input  logic [31:0]   req_instr,
  input  logic [DW-1:0] req_wdata,
  output logic [1:0]    resp_code,
  output logic [DW-1:0] resp_rdata,
  output logic          fiq_n,
  output logic          irq_n
);
  localparam int unsigned AW  = $clog2(NREG);
  localparam int unsigned WCW = $clog2(LONG_LAST + 1);

  logic           rd_en, rf_we, rf_src_cnt, busy_start, finish_hit;
  logic [AW-1:0]  rd_addr, opnd_addr, rf_waddr;
  logic [DW-1:0]  ra_data, opnd, count, rf_wdata;
  logic [1:0]     sched, rel;
  logic           wc_we;
  logic [WCW-1:0] wc_next, wcnt_q;
  logic [NUM_LINES-1:0] line_n;

  tcop_decode #(
    .CP_A(CP_A), .CP_B(CP_B), .AW(AW), .LONG_LAST(LONG_LAST)
  ) u_dec (
    .req_valid (req_valid),
    .req_first (req_first),
    .req_kind  (req_kind),
    .req_cpnum (req_cpnum),
    .req_instr (req_instr),
    .opnd_zero (opnd == '0),
    .finish_hit(finish_hit),
    .wcnt      (wcnt_q),
    .rsp       (resp_code),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .opnd_addr (opnd_addr),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .rf_src_cnt(rf_src_cnt),
    .busy_start(busy_start),
    .sched     (sched),
    .rel       (rel),
    .wc_we     (wc_we),
    .wc_next   (wc_next)
  );

  assign rf_wdata = rf_src_cnt ? count : req_wdata;

  tcop_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (rf_we),
    .waddr  (rf_waddr),
    .wdata  (rf_wdata),
    .ra_addr(rd_addr),
    .ra_data(ra_data),
    .rb_addr(opnd_addr),
    .rb_data(opnd)
  );

  tcop_timer #(.DW(DW)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (busy_start),
    .opnd      (opnd),
    .count     (count),
    .finish_hit(finish_hit)
  );

  for (genvar gl = 0; gl < NUM_LINES; gl++) begin : g_line
    tcop_irq_line #(.DW(DW)) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .sched (sched[gl]),
      .rel   (rel[gl]),
      .delay (opnd),
      .line_n(line_n[gl])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wcnt_q <= '0;
    else if (wc_we) wcnt_q <= wc_next;
  end

  assign resp_rdata = rd_en ? ra_data : '0;
  assign fiq_n      = line_n[LINE_FAST];
  assign irq_n      = line_n[LINE_NORM];
endmodule

// File: rtl/tcop_chk.sv
module tcop_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_first,
  input logic [2:0]    req_kind,
  input logic [3:0]    req_cpnum,
  input logic [31:0]   req_instr,
  input logic [DW-1:0] req_wdata,
  input logic [1:0]    resp_code,
  input logic [DW-1:0] resp_rdata,
  input logic          fiq_n,
  input logic          irq_n,
  input logic          rf_we,
  input logic [DW-1:0] opnd
);
  logic ours, on_b, dp;
  assign ours = (req_cpnum == 4'd4) || (req_cpnum == 4'd5);
  assign on_b = (req_cpnum == 4'd5);
  assign dp   = req_valid && (req_kind == 3'd4);

  // R3
  foreign_cp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ours) |-> (resp_code == 2'd3 && !rf_we));

  // R4
  ldst_on_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && on_b && (req_kind == 3'd2 || req_kind == 3'd3))
      |-> (resp_code == 2'd3 && !rf_we));

  // R2
  reg_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ours && req_kind == 3'd1
      && $past(req_valid && ours && req_kind == 3'd0)
      && $past(req_instr[19:16]) == req_instr[19:16])
      |-> (resp_rdata == $past(req_wdata)));

  // R6
  wait_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp && ours && req_instr[23:20] == 4'd0 && req_first)
      |-> (resp_code == ((opnd == '0) ? 2'd0 : 2'd1)));

  // R7
  fast_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp && on_b && req_instr[23:20] == 4'd1 && opnd == '0) |=> !fiq_n);

  // R8
  fast_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp && on_b && req_instr[23:20] == 4'd3) |=> fiq_n);

  // R8
  norm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp && on_b && req_instr[23:20] == 4'd4) |=> irq_n);

  // R10
  a_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp && req_cpnum == 4'd4 && req_instr[23:20] != 4'd0)
      |-> (resp_code == 2'd3 && !rf_we));
endmodule

bind timed_test_cop tcop_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_first (req_first),
  .req_kind  (req_kind),
  .req_cpnum (req_cpnum),
  .req_instr (req_instr),
  .req_wdata (req_wdata),
  .resp_code (resp_code),
  .resp_rdata(resp_rdata),
  .fiq_n     (fiq_n),
  .irq_n     (irq_n),
  .rf_we     (rf_we),
  .opnd      (opnd)
);

// File: tb/timed_test_cop_tb.sv
module timed_test_cop_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_first;
  logic [2:0]  req_kind;
  logic [3:0]  req_cpnum;
  logic [31:0] req_instr, req_wdata;
  logic [1:0]  resp_code;
  logic [31:0] resp_rdata;
  logic        fiq_n, irq_n;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0]  r_code;
  logic [31:0] r_data;

  localparam logic [1:0] DONE = 2'd0, BUSY = 2'd1, INC = 2'd2, CANT = 2'd3;

  always #5 clk = ~clk;

  timed_test_cop u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_first(req_first),
    .req_kind(req_kind), .req_cpnum(req_cpnum), .req_instr(req_instr),
    .req_wdata(req_wdata), .resp_code(resp_code), .resp_rdata(resp_rdata),
    .fiq_n(fiq_n), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] rn,
                                     input logic [3:0] rd, input logic [3:0] rm,
                                     input logic lng);
    logic [31:0] w;
    w = {8'h00, op, rn, rd, 8'h00, rm};
    if (lng) w[22] = 1'b1;
    return w;
  endfunction

  task automatic beat(input logic [2:0] k, input logic [3:0] cp, input logic [31:0] ins,
                      input logic [31:0] wd, input logic fst);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_cpnum = cp;
    req_instr = ins;  req_wdata = wd; req_first = fst;
    #1;
    r_code = resp_code;
    r_data = resp_rdata;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] cp, input logic [3:0] rg, input logic [31:0] v);
    beat(3'd0, cp, mk(4'd0, rg, 4'd0, 4'd0, 1'b0), v, 1'b1);
  endtask

  task automatic rd(input logic [3:0] cp, input logic [3:0] rg);
    beat(3'd1, cp, mk(4'd0, rg, 4'd0, 4'd0, 1'b0), 32'h0, 1'b1);
  endtask

  task automatic dp(input logic [3:0] cp, input logic [3:0] op, input logic [3:0] rm);
    beat(3'd4, cp, mk(op, 4'd0, 4'd0, rm, 1'b0), 32'h0, 1'b1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 fiq_n after reset", 32'(fiq_n), 32'd1);
    chk("R1 irq_n after reset", 32'(irq_n), 32'd1);
    rd(4'd4, 4'd0);  chk("R1 reg0 zero", r_data, 32'h0);
    rd(4'd5, 4'd15); chk("R1 reg15 zero", r_data, 32'h0);
  endtask

  task automatic t_regs;
    wr(4'd4, 4'd3, 32'hCAFE_0003); chk("R2 write code", 32'(r_code), 32'(DONE));
    wr(4'd5, 4'd12, 32'h1234_5678);
    rd(4'd5, 4'd3);  chk("R2 read via 5", r_data, 32'hCAFE_0003);
    chk("R2 read code", 32'(r_code), 32'(DONE));
    rd(4'd4, 4'd12); chk("R2 read via 4", r_data, 32'h1234_5678);
  endtask

  task automatic t_foreign;
    wr(4'd7, 4'd3, 32'hDEAD_BEEF); chk("R3 foreign write code", 32'(r_code), 32'(CANT));
    rd(4'd4, 4'd3); chk("R3 reg untouched", r_data, 32'hCAFE_0003);
    beat(3'd4, 4'd15, mk(4'd1, 4'd0, 4'd0, 4'd0, 1'b0), 32'h0, 1'b1);
    chk("R3 foreign dp code", 32'(r_code), 32'(CANT));
    @(negedge clk); chk("R3 fiq_n untouched", 32'(fiq_n), 32'd1);
  endtask

  task automatic t_ldst;
    beat(3'd2, 4'd4, mk(4'd0, 4'd0, 4'd9, 4'd0, 1'b0), 32'hA5A5_0009, 1'b1);
    chk("R4 short load code", 32'(r_code), 32'(DONE));
    beat(3'd3, 4'd4, mk(4'd0, 4'd0, 4'd9, 4'd0, 1'b0), 32'h0, 1'b1);
    chk("R4 short store data", r_data, 32'hA5A5_0009);
    chk("R5 short store code", 32'(r_code), 32'(DONE));
    beat(3'd2, 4'd5, mk(4'd0, 4'd0, 4'd9, 4'd0, 1'b0), 32'h1111_1111, 1'b1);
    chk("R4 load on 5 code", 32'(r_code), 32'(CANT));
    beat(3'd3, 4'd5, mk(4'd0, 4'd0, 4'd9, 4'd0, 1'b0), 32'h0, 1'b1);
    chk("R4 store on 5 code", 32'(r_code), 32'(CANT));
    rd(4'd4, 4'd9); chk("R4 reg after refused load", r_data, 32'hA5A5_0009);
  endtask

  task automatic t_long;
    for (int i = 0; i < 5; i++) begin
      beat(3'd2, 4'd4, mk(4'd0, 4'd0, 4'd8, 4'd0, 1'b1), 32'h100 + 32'(i), (i == 0));
      chk("R5 long load code", 32'(r_code), (i == 4) ? 32'(DONE) : 32'(INC));
    end
    rd(4'd4, 4'd8); chk("R5 last beat kept", r_data, 32'h104);
    for (int i = 0; i < 2; i++)
      beat(3'd3, 4'd4, mk(4'd0, 4'd0, 4'd8, 4'd0, 1'b1), 32'h0, (i == 0));
    for (int i = 0; i < 5; i++) begin
      beat(3'd3, 4'd4, mk(4'd0, 4'd0, 4'd8, 4'd0, 1'b1), 32'h0, (i == 0));
      chk("R5 restarted store code", 32'(r_code), (i == 4) ? 32'(DONE) : 32'(INC));
      chk("R5 long store data", r_data, 32'h104);
    end
  endtask

  task automatic t_busy;
    int nbusy;
    wr(4'd4, 4'd5, 32'd4);
    dp(4'd4, 4'd0, 4'd5);
    nbusy = (r_code == BUSY) ? 1 : 0;
    for (int i = 0; i < 20 && r_code == BUSY; i++) begin
      beat(3'd4, 4'd4, mk(4'd0, 4'd0, 4'd0, 4'd5, 1'b0), 32'h0, 1'b0);
      if (r_code == BUSY) nbusy++;
    end
    chk("R6 busy cycles d=4", 32'(nbusy), 32'd4);
    chk("R6 ends done", 32'(r_code), 32'(DONE));
    wr(4'd5, 4'd15, 32'd0);
    dp(4'd5, 4'd0, 4'd15); chk("R6 zero count done", 32'(r_code), 32'(DONE));
  endtask

  task automatic t_irq;
    wr(4'd5, 4'd2, 32'd3);
    dp(4'd5, 4'd1, 4'd2); chk("R7 schedule code", 32'(r_code), 32'(DONE));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); chk("R7 fiq_n still high", 32'(fiq_n), 32'd1);
    end
    @(negedge clk); chk("R7 fiq_n low at d", 32'(fiq_n), 32'd0);
    chk("R7 irq_n unaffected", 32'(irq_n), 32'd1);
    dp(4'd5, 4'd3, 4'd0);
    @(negedge clk); chk("R8 fiq_n released", 32'(fiq_n), 32'd1);
    wr(4'd5, 4'd3, 32'd0);
    dp(4'd5, 4'd2, 4'd3);
    @(negedge clk); chk("R7 irq_n low at once", 32'(irq_n), 32'd0);
    dp(4'd5, 4'd4, 4'd0);
    @(negedge clk); chk("R8 irq_n released", 32'(irq_n), 32'd1);
  endtask

  task automatic t_replace;
    wr(4'd5, 4'd4, 32'd10);
    wr(4'd5, 4'd2, 32'd2);
    dp(4'd5, 4'd1, 4'd4);
    dp(4'd5, 4'd1, 4'd2);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); chk("R7 replaced countdown high", 32'(fiq_n), 32'd1);
    end
    @(negedge clk); chk("R7 replaced countdown low", 32'(fiq_n), 32'd0);
    dp(4'd5, 4'd3, 4'd0);
    repeat (15) @(negedge clk);
    chk("R7 old countdown discarded", 32'(fiq_n), 32'd1);
  endtask

  task automatic t_snap;
    logic [31:0] a;
    dp(4'd5, 4'd5, 4'd6);
    repeat (3) @(posedge clk);
    dp(4'd5, 4'd5, 4'd7);
    rd(4'd5, 4'd6); a = r_data;
    rd(4'd5, 4'd7);
    chk("R9 snapshot gap", r_data - a, 32'd4);
  endtask

  task automatic t_reject;
    wr(4'd4, 4'd9, 32'h0000_0077);
    dp(4'd4, 4'd5, 4'd9); chk("R10 snapshot on 4 refused", 32'(r_code), 32'(CANT));
    rd(4'd4, 4'd9); chk("R10 reg untouched", r_data, 32'h0000_0077);
    wr(4'd4, 4'd1, 32'd0);
    dp(4'd4, 4'd1, 4'd1); chk("R10 fast schedule on 4 refused", 32'(r_code), 32'(CANT));
    @(negedge clk); chk("R10 fiq_n untouched", 32'(fiq_n), 32'd1);
    dp(4'd5, 4'd7, 4'd1); chk("R10 opcode 7 refused", 32'(r_code), 32'(CANT));
    dp(4'd4, 4'd15, 4'd1); chk("R10 opcode 15 refused", 32'(r_code), 32'(CANT));
  endtask

  initial begin
    req_valid = 1'b0; req_first = 1'b0; req_kind = 3'd0; req_cpnum = 4'd0;
    req_instr = 32'h0; req_wdata = 32'h0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset;
    t_regs;
    t_foreign;
    t_ldst;
    t_long;
    t_busy;
    t_irq;
    t_replace;
    t_snap;
    t_reject;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule